// File: doc/BRIEF.md
# SPI Command and Response Port

This block is a serial target that a host controller reaches through four pins: a serial clock, a data input line, an active-low select, and a data line the target drives back. Each transaction opens when select falls. The first eight bits clocked in form an opcode. The opcode either starts a command write of fixed length, or starts a read of the status byte or of the full response. A read can leave on the shared data line or on a separate alternate output pin. Because both outputs are tri-state, each one is presented as a data bit plus an output-enable.

The pins are sampled by a faster system clock. They pass through synchronizers, and edges on the serial clock are found by comparing each sample with the one before it. A command is delivered to the core only when select rises after exactly the right number of data bits. In that case the block raises a single-cycle valid strobe and updates the command word. Any other ending discards the command: an abort, a short transfer or an overlong transfer. Opcodes outside the legal set make the target ignore the rest of the transaction.

Top module: `spi_cmd_port`

## Requirements
- R1: After reset, both output-enables are low, `cmd_valid` is low and `cmd_data` is zero.
- R2: After select falls, the opcode is taken from the data input on the first eight serial-clock rising edges, most significant bit first.
- R3: Opcode 0x48 starts a command write. If select rises after exactly 64 further bits, `cmd_valid` pulses high for one system-clock cycle and `cmd_data` holds the 8 bytes. The first byte received is in bits [63:56]. Neither output driver turns on during a write.
- R4: A command write that ends with fewer or more than 64 data bits raises no `cmd_valid`, and `cmd_data` keeps its previous value.
- R5: Opcode 0x80 sends one byte on the data line, MSB first. Each bit is driven after a serial-clock falling edge, so the host samples it on the next rising edge. The first bit follows the falling edge that comes after the opcode's eighth rising edge.
- R6: Opcode 0xC0 sends 16 bytes on the data line. The status byte goes first, then the response bytes in order. Response byte 1 is taken from `rsp_data[119:112]` and byte 15 from `rsp_data[7:0]`. The values used are those present when the opcode completes.
- R7: Opcodes 0xA0 and 0xE0 send the same 1-byte and 16-byte frames on the alternate pin. The data-line enable stays low during these reads. During 0x80 and 0xC0 reads, the alternate enable stays low.
- R8: The status byte is `{cts, status_flags[6:0]}`, so bit 7 reports clear-to-send.
- R9: For any other opcode, the target drives nothing and raises no `cmd_valid`, and `cmd_data` is unchanged, until select rises.
- R10: The active driver is released (enable low) on the falling edge that follows the last bit of the frame. It is also released when select rises, including during an aborted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_csn | input | 1 | Active-low select |
| spi_sdio_i | input | 1 | Data line as seen at the pin |
| spi_sdio_o | output | 1 | Data line value driven by the target |
| spi_sdio_oe | output | 1 | Data line output-enable |
| alt_dout | output | 1 | Alternate read output value |
| alt_oe | output | 1 | Alternate read output-enable |
| cts | input | 1 | Clear-to-send flag from the core |
| status_flags | input | 7 | Remaining status bits from the core |
| rsp_data | input | 8*(RSP_BYTES-1) | Response bytes 1 to 15, byte 1 most significant |
| cmd_valid | output | 1 | One-cycle strobe for a complete command |
| cmd_data | output | 8*CMD_BYTES | Last complete command, first byte most significant |

## Verification
The assertions assume the serial clock is much slower than the system clock. Each half period must span several system cycles, so that every pin edge is seen after the synchronizers. They also assume that select and data do not change in the same sample as a clock edge. The bench holds each serial half period for eight system cycles. It changes the data input only right after a falling edge, and it moves select only while the serial clock is low. It keeps the status and response inputs stable for the whole of each read.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam logic [7:0] OP_CMD_WR   = 8'h48;
  localparam logic [7:0] OP_STAT_IO  = 8'h80;
  localparam logic [7:0] OP_RESP_IO  = 8'hC0;
  localparam logic [7:0] OP_STAT_ALT = 8'hA0;
  localparam logic [7:0] OP_RESP_ALT = 8'hE0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_WR,
    ST_RD,
    ST_IGN
  } port_state_t;

  typedef struct packed {
    logic legal;
    logic is_wr;
    logic is_long;
    logic on_alt;
  } op_info_t;

  // Map an opcode to its operation; anything unlisted is illegal.
  function automatic op_info_t decode_op(input logic [7:0] op);
    op_info_t r;
    r = '0;
    case (op)
      OP_CMD_WR:   begin r.legal = 1'b1; r.is_wr = 1'b1; end
      OP_STAT_IO:  begin r.legal = 1'b1; end
      OP_RESP_IO:  begin r.legal = 1'b1; r.is_long = 1'b1; end
      OP_STAT_ALT: begin r.legal = 1'b1; r.on_alt = 1'b1; end
      OP_RESP_ALT: begin r.legal = 1'b1; r.is_long = 1'b1; r.on_alt = 1'b1; end
      default:     r = '0;
    endcase
    return r;
  endfunction

  // Count up, but stop one past the limit so "too many" stays visible.
  function automatic int unsigned sat_next(input int unsigned cnt,
                                           input int unsigned limit);
    return (cnt > limit) ? cnt : cnt + 1;
  endfunction

  // Number of bits a read frame carries.
  function automatic int unsigned read_len(input logic is_long,
                                           input int unsigned frame_bits);
    return is_long ? frame_bits : 8;
  endfunction

endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_pin,
  input  logic csn_pin,
  input  logic sdi_pin,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic csn_hi,
  output logic csn_rise,
  output logic sdi
);
  // bit 0 serial clock, bit 1 select, bit 2 data
  localparam logic [2:0] RST_VAL = 3'b010;

  logic [2:0] pin_v;
  logic [2:0] stg [STAGES];
  logic [2:0] cur;
  logic [1:0] prev;

  assign pin_v = {sdi_pin, csn_pin, sclk_pin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      prev <= RST_VAL[1:0];
    end else begin
      stg[0] <= pin_v;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev <= stg[STAGES-1][1:0];
    end
  end

  assign cur       = stg[STAGES-1];
  assign sclk_rise = cur[0] & ~prev[0];
  assign sclk_fall = ~cur[0] & prev[0];
  assign csn_hi    = cur[1];
  assign csn_rise  = cur[1] & ~prev[1];
  assign sdi       = cur[2];

endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx #(
  parameter int WR_BITS = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               rise,
  input  logic               sdi,
  input  logic               op_phase,
  input  logic               wr_phase,
  output logic               op_done,
  output logic [7:0]         op_byte,
  output logic               wr_exact,
  output logic [WR_BITS-1:0] wr_word
);
  import spi_cmd_pkg::*;

  localparam int CW = $clog2(WR_BITS + 2);

  logic [2:0]    op_cnt;
  logic [CW-1:0] wr_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_cnt  <= '0;
      op_byte <= '0;
      op_done <= 1'b0;
      wr_cnt  <= '0;
      wr_word <= '0;
    end else if (clear) begin
      op_cnt  <= '0;
      op_done <= 1'b0;
      wr_cnt  <= '0;
    end else begin
      op_done <= 1'b0;
      if (op_phase && rise) begin
        op_byte <= {op_byte[6:0], sdi};
        op_cnt  <= op_cnt + 3'd1;
        op_done <= (op_cnt == 3'd7);
      end
      if (wr_phase && rise) begin
        if (int'(wr_cnt) < WR_BITS) wr_word <= {wr_word[WR_BITS-2:0], sdi};
        wr_cnt <= CW'(sat_next(int'(wr_cnt), WR_BITS));
      end
    end
  end

  assign wr_exact = (int'(wr_cnt) == WR_BITS);

  // R4
  wr_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wr_cnt) <= WR_BITS + 1);

endmodule

// File: rtl/spi_cmd_tx.sv
module spi_cmd_tx #(
  parameter int FRAME_BITS = 128
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  release_i,
  input  logic                  load,
  input  logic                  load_long,
  input  logic                  load_alt,
  input  logic [FRAME_BITS-1:0] frame_in,
  input  logic                  fall,
  output logic                  sdio_o,
  output logic                  sdio_oe,
  output logic                  alt_o,
  output logic                  alt_oe
);
  import spi_cmd_pkg::*;

  localparam int LW = $clog2(FRAME_BITS + 1);

  logic [FRAME_BITS-1:0] frame;
  logic [LW-1:0]         bits_left;
  logic                  drv_on;
  logic                  sel_alt;
  logic                  dout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame     <= '0;
      bits_left <= '0;
      drv_on    <= 1'b0;
      sel_alt   <= 1'b0;
      dout      <= 1'b0;
    end else if (release_i) begin
      bits_left <= '0;
      drv_on    <= 1'b0;
    end else if (load) begin
      frame     <= frame_in;
      bits_left <= LW'(read_len(load_long, FRAME_BITS));
      sel_alt   <= load_alt;
    end else if (fall) begin
      if (bits_left != '0) begin
        dout      <= frame[FRAME_BITS-1];
        frame     <= {frame[FRAME_BITS-2:0], 1'b0};
        bits_left <= bits_left - LW'(1);
        drv_on    <= 1'b1;
      end else begin
        drv_on    <= 1'b0;
      end
    end
  end

  assign sdio_o  = dout;
  assign alt_o   = dout;
  assign sdio_oe = drv_on & ~sel_alt;
  assign alt_oe  = drv_on & sel_alt;

  // R10
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_i |=> (!sdio_oe && !alt_oe));

  // R10
  drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !release_i && !load && bits_left == '0) |=> !drv_on);

endmodule

// File: rtl/spi_cmd_port.sv
module spi_cmd_port #(
  parameter int CMD_BYTES   = 8,
  parameter int RSP_BYTES   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       spi_sclk,
  input  logic                       spi_csn,
  input  logic                       spi_sdio_i,
  output logic                       spi_sdio_o,
  output logic                       spi_sdio_oe,
  output logic                       alt_dout,
  output logic                       alt_oe,
  input  logic                       cts,
  input  logic [6:0]                 status_flags,
  input  logic [8*(RSP_BYTES-1)-1:0] rsp_data,
  output logic                       cmd_valid,
  output logic [8*CMD_BYTES-1:0]     cmd_data
);
  import spi_cmd_pkg::*;

  localparam int WR_BITS    = 8 * CMD_BYTES;
  localparam int FRAME_BITS = 8 * RSP_BYTES;

  // events between the pieces, named for the assertions
  logic        sclk_rise, sclk_fall, csn_hi, csn_rise, sdi_s;
  logic        op_done, wr_exact, rd_load, commit;
  logic [7:0]  op_byte;
  logic [WR_BITS-1:0] wr_word;
  op_info_t    info;
  port_state_t state;

  spi_cmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_pin  (spi_sclk),
    .csn_pin   (spi_csn),
    .sdi_pin   (spi_sdio_i),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .csn_hi    (csn_hi),
    .csn_rise  (csn_rise),
    .sdi       (sdi_s)
  );

  spi_cmd_rx #(.WR_BITS(WR_BITS)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (csn_hi),
    .rise     (sclk_rise),
    .sdi      (sdi_s),
    .op_phase (state == ST_OPC),
    .wr_phase (state == ST_WR),
    .op_done  (op_done),
    .op_byte  (op_byte),
    .wr_exact (wr_exact),
    .wr_word  (wr_word)
  );

  assign info    = decode_op(op_byte);
  assign rd_load = op_done && (state == ST_OPC) && info.legal && !info.is_wr;
  assign commit  = csn_rise && (state == ST_WR) && wr_exact;

  spi_cmd_tx #(.FRAME_BITS(FRAME_BITS)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .release_i (csn_hi),
    .load      (rd_load),
    .load_long (info.is_long),
    .load_alt  (info.on_alt),
    .frame_in  ({cts, status_flags, rsp_data}),
    .fall      (sclk_fall),
    .sdio_o    (spi_sdio_o),
    .sdio_oe   (spi_sdio_oe),
    .alt_o     (alt_dout),
    .alt_oe    (alt_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else if (csn_hi) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: state <= ST_OPC;
        ST_OPC: if (op_done) begin
          if (!info.legal)     state <= ST_IGN;
          else if (info.is_wr) state <= ST_WR;
          else                 state <= ST_RD;
        end
        default: state <= state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_data  <= '0;
    end else begin
      cmd_valid <= commit;
      if (commit) cmd_data <= wr_word;
    end
  end

  // R3
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R7
  valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ($past(state) == ST_WR));

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> $stable(cmd_data));

  // R9
  ign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGN) |-> (!spi_sdio_oe && !alt_oe));

  // R7
  one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(spi_sdio_oe && alt_oe));

endmodule

// File: tb/spi_cmd_port_bench.sv
module spi_cmd_port_bench;
  localparam int CMD_BYTES = 8;
  localparam int RSP_BYTES = 16;
  localparam int HALF      = 8;
  localparam int RW        = 8 * (RSP_BYTES - 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, sclk, csn, sdi, cts;
  logic [6:0] flags;
  logic [RW-1:0] rsp;
  logic sdio_o, sdio_oe, alt_dout, alt_oe, cmd_valid;
  logic [8*CMD_BYTES-1:0] cmd_data;

  int errors = 0, checks = 0;
  int vcount = 0, io_cnt = 0, alt_cnt = 0;

  spi_cmd_port u_spi_cmd_port (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_csn(csn),
    .spi_sdio_i(sdi), .spi_sdio_o(sdio_o), .spi_sdio_oe(sdio_oe),
    .alt_dout(alt_dout), .alt_oe(alt_oe), .cts(cts),
    .status_flags(flags), .rsp_data(rsp), .cmd_valid(cmd_valid),
    .cmd_data(cmd_data)
  );

  always @(posedge clk) begin
    if (cmd_valid) vcount++;
    if (sdio_oe)   io_cnt++;
    if (alt_oe)    alt_cnt++;
  end

  task automatic check(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit legal_op(input logic [7:0] op);
    return op == 8'h48 || op == 8'h80 || op == 8'hC0 || op == 8'hA0 || op == 8'hE0;
  endfunction

  // Expected read frame byte k: status first, then response bytes 1..15.
  function automatic logic [7:0] frame_byte(input int k);
    if (k == 0) return {cts, flags};
    return rsp[8*(RSP_BYTES-1-k) +: 8];
  endfunction

  task automatic xfer(input logic [7:0] tx, output logic [7:0] got_io,
                      output logic [7:0] got_alt, output int io_on, output int alt_on);
    io_on = 0; alt_on = 0;
    for (int i = 7; i >= 0; i--) begin
      sdi = tx[i];
      wait_clk(HALF);
      got_io[i]  = sdio_o;
      got_alt[i] = alt_dout;
      io_on  += int'(sdio_oe);
      alt_on += int'(alt_oe);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic open_t();
    csn = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic close_t();
    wait_clk(HALF);
    csn = 1'b1;
    wait_clk(HALF);
    sclk = 1'b1;
    wait_clk(HALF);
    sclk = 1'b0;
    wait_clk(2 * HALF);
  endtask

  task automatic do_write(input int n, input string req);
    logic [7:0] b, gi, ga;
    logic [63:0] expw, prev;
    int v0, i0, a0, ion, aon;
    expw = '0; prev = cmd_data; v0 = vcount; i0 = io_cnt; a0 = alt_cnt;
    open_t();
    xfer(8'h48, gi, ga, ion, aon);
    for (int k = 0; k < n; k++) begin
      b = 8'($urandom);
      if (k < 8) expw = {expw[55:0], b};
      xfer(b, gi, ga, ion, aon);
    end
    close_t();
    if (n == 8) begin
      check(vcount - v0 == 1, {req, " valid pulse"}, 128'(vcount - v0), 128'd1);
      check(cmd_data == expw, {req, " cmd_data"}, 128'(cmd_data), 128'(expw));
    end else begin
      check(vcount == v0, {req, " no pulse"}, 128'(vcount - v0), 128'd0);
      check(cmd_data == prev, {req, " data kept"}, 128'(cmd_data), 128'(prev));
    end
    check(io_cnt == i0 && alt_cnt == a0, "R3 drivers off in write",
          128'(io_cnt - i0 + alt_cnt - a0), 128'd0);
  endtask

  task automatic do_read(input logic [7:0] op, input int nsent, input bit alt,
                         input bit is_long, input string req);
    logic [7:0] gi, ga, got;
    int ion, aon, len, v0;
    len = is_long ? RSP_BYTES : 1;
    v0 = vcount;
    open_t();
    xfer(op, gi, ga, ion, aon);
    for (int k = 0; k < nsent; k++) begin
      xfer(8'h00, gi, ga, ion, aon);
      got = alt ? ga : gi;
      check(got == frame_byte(k), req, 128'(got), 128'(frame_byte(k)));
      check(ion == (alt ? 0 : 8) && aon == (alt ? 8 : 0), "R7 pin select",
            128'({ion[15:0], aon[15:0]}),
            128'({alt ? 16'd0 : 16'd8, alt ? 16'd8 : 16'd0}));
    end
    wait_clk(HALF);
    if (nsent == len)
      check(!sdio_oe && !alt_oe, "R10 release after last bit",
            128'({sdio_oe, alt_oe}), 128'd0);
    else
      check(alt ? alt_oe : sdio_oe, "R10 still driving before abort", 128'd0, 128'd1);
    close_t();
    check(!sdio_oe && !alt_oe, "R10 release on select", 128'({sdio_oe, alt_oe}), 128'd0);
    check(vcount == v0, "R7 no valid on read", 128'(vcount - v0), 128'd0);
  endtask

  task automatic do_illegal(input logic [7:0] op, input string req);
    logic [7:0] gi, ga;
    logic [63:0] prev;
    int v0, i0, a0, ion, aon;
    prev = cmd_data; v0 = vcount; i0 = io_cnt; a0 = alt_cnt;
    open_t();
    xfer(op, gi, ga, ion, aon);
    for (int k = 0; k < CMD_BYTES; k++) xfer(8'($urandom), gi, ga, ion, aon);
    close_t();
    check(vcount == v0 && cmd_data == prev, {req, " no command"},
          128'(cmd_data), 128'(prev));
    check(io_cnt == i0 && alt_cnt == a0, {req, " no driver"},
          128'(io_cnt - i0 + alt_cnt - a0), 128'd0);
  endtask

  task automatic new_rsp();
    cts   = 1'($urandom);
    flags = 7'($urandom);
    for (int k = 0; k < RW / 8; k++) rsp[8*k +: 8] = 8'($urandom);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] op;
    void'($urandom(32'd4242));
    rst_n = 1'b0; sclk = 1'b0; csn = 1'b1; sdi = 1'b0;
    cts = 1'b0; flags = '0; rsp = '0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(4);
    // R1
    check(!sdio_oe && !alt_oe && !cmd_valid && cmd_data == '0, "R1 reset state",
          128'({sdio_oe, alt_oe, cmd_valid, cmd_data}), 128'd0);

    // R3 and R2: legal writes with random payloads
    for (int t = 0; t < 4; t++) do_write(8, "R3");
    // R4: short, long, empty
    do_write(7, "R4 short");
    do_write(9, "R4 long");
    do_write(0, "R4 empty");
    do_write(8, "R3 after discard");

    // R8: clear-to-send both ways
    cts = 1'b1; flags = 7'h2A;
    do_read(8'h80, 1, 1'b0, 1'b0, "R8 status cts=1");
    cts = 1'b0; flags = 7'h55;
    do_read(8'h80, 1, 1'b0, 1'b0, "R8 status cts=0");

    for (int t = 0; t < 2; t++) begin
      new_rsp();
      do_read(8'h80, 1, 1'b0, 1'b0, "R5 short sdio read");
      new_rsp();
      do_read(8'hC0, 16, 1'b0, 1'b1, "R6 long sdio read");
      new_rsp();
      do_read(8'hA0, 1, 1'b1, 1'b0, "R7 short alt read");
      new_rsp();
      do_read(8'hE0, 16, 1'b1, 1'b1, "R7 long alt read");
    end

    // R10: aborted reads, then a command must still work
    new_rsp();
    do_read(8'hC0, 3, 1'b0, 1'b1, "R6 aborted read");
    new_rsp();
    do_read(8'hE0, 5, 1'b1, 1'b1, "R7 aborted alt read");
    do_write(8, "R3 after abort");

    // R2: bit-reversed write opcode must not be taken as a write
    do_illegal(8'h12, "R2 msb-first");
    // R9: random illegal opcodes
    for (int t = 0; t < 3; t++) begin
      op = 8'($urandom);
      while (legal_op(op)) op = 8'($urandom);
      do_illegal(op, "R9 illegal opcode");
    end
    do_write(8, "R3 after illegal");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule